// File: doc/BRIEF.md
# SD Command Frame Transmitter

This block turns one command request into a 48-bit frame on a single-wire, SD/MMC-style command line. A one-cycle start strobe loads a 6-bit command index and a 32-bit argument. The block then sends, most significant bit first, a zero start bit, a one transmitter bit, the index, the argument, a 7-bit CRC and a one end bit. The CRC is computed bit by bit while the message leaves the block, so the frame is never stored whole.

An output-enable shows when the line is driven. Outside a frame it is low, and the pad above the block places the line in high impedance. A select input chooses whether line bits change on the rising or the falling edge of the clock. A one-cycle done pulse marks the end of each frame. A start that arrives while a frame is being sent is ignored.

Top module: `sd_cmd_tx`

## Requirements
- R1: After reset, and in every cycle when no frame is being sent, `cmd_oe` is 0 and `done` is 0.
- R2: A start sampled at rising edge E0 sends frame bit 47 at rising edge E1 and each later bit one cycle after the previous one. Frame bit 47 is 0 and bit 46 is 1. Bits 45..40 carry `cmd_idx[5:0]` and bits 39..8 carry `cmd_arg[31:0]`, each most significant bit first.
- R3: Frame bits 7..1 carry a 7-bit CRC, most significant bit first. The CRC is the remainder of M(x)·x^7 divided by x^7+x^3+1, where M(x) is frame bits 47..8 and bit 47 is the highest-order term.
- R4: Frame bit 0 is the end bit and is 1. `cmd_oe` is 1 for exactly the 48 bit cycles.
- R5: `done` is high for exactly one cycle: the cycle after the end bit. In that cycle `cmd_oe` is already 0.
- R6: With `fall_edge`=0, `cmd_out` and `cmd_oe` change at the rising clock edge. With `fall_edge`=1 they change at the next falling edge, half a cycle later, and carry the same values.
- R7: A start raised while a frame is in progress has no effect. The frame being sent does not change, and no second frame follows it.
- R8: Index 0 with argument 0 gives CRC 7'h4A. Index 17 with argument 0 gives CRC 7'h2A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe; ignored while a frame is in progress |
| fall_edge | input | 1 | 1 = line changes on the falling edge, 0 = on the rising edge |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_out | output | 1 | Command line data; 1 when not driven |
| cmd_oe | output | 1 | Line drive enable; 0 = high impedance |
| done | output | 1 | One-cycle pulse after the end bit |

## Verification
The block has no parameters: the frame format fixes every width. The bench therefore builds the single configuration and spreads its effort over the inputs instead. Random indices and arguments are sent in both edge modes, so every CRC feedback path and both output stages are exercised. Directed frames check the two known CRC values and an all-ones frame. A quarter-cycle probe after each rising edge shows which clock edge moved the line. Starts injected in the middle of a frame, with altered inputs, show that a frame in progress cannot be disturbed.

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        fall_edge,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic        done
);
  localparam int MSG_BITS = 40;
  localparam int FRAME_BITS = 48;
  localparam logic [5:0] MSG_END = 6'(MSG_BITS);
  localparam logic [5:0] LAST = 6'(FRAME_BITS - 1);

  logic        busy;
  logic [5:0]  cnt;
  logic [39:0] msg;
  logic [6:0]  crc;
  logic        bit_q, oe_q, out_n, oe_n, done_q;

  wire fb      = msg[39] ^ crc[6];
  wire cur_bit = (cnt < MSG_END) ? msg[39] : (cnt < LAST) ? crc[6] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      msg    <= '0;
      crc    <= '0;
      bit_q  <= 1'b1;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= oe_q && !busy;
      oe_q   <= busy;
      bit_q  <= busy ? cur_bit : 1'b1;
      if (busy) begin
        cnt <= cnt + 6'd1;
        if (cnt < MSG_END) begin
          msg <= {msg[38:0], 1'b0};
          crc <= {crc[5:3], crc[2] ^ fb, crc[1:0], fb};
        end else begin
          crc <= {crc[5:0], 1'b0};
        end
        if (cnt == LAST) busy <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        msg  <= {2'b01, cmd_idx, cmd_arg};
        crc  <= '0;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_n <= 1'b1;
      oe_n  <= 1'b0;
    end else begin
      out_n <= bit_q;
      oe_n  <= oe_q;
    end
  end

  assign cmd_out = fall_edge ? out_n : bit_q;
  assign cmd_oe  = fall_edge ? oe_n  : oe_q;
  assign done    = done_q;

  a_r2_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !bit_q);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r5_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!oe_q && $past(oe_q) && $past(bit_q)));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 6'd1));

  a_r6_half_cycle_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n == oe_q) && (!oe_q || out_n == bit_q));
endmodule

// File: tb/sd_cmd_tx_test.sv
module sd_cmd_tx_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        fall_edge = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_out, cmd_oe, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  sd_cmd_tx uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fall_edge(fall_edge),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [46:0] r;
    r = {m, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r = r ^ (47'h89 << (i - 7));
    return r[6:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [5:0] idx, input logic [31:0] arg,
                           input bit fe, input bit inject, output logic [6:0] got_crc);
    logic [47:0] f;
    logic [6:0]  c;
    string req;
    c = ref_crc({2'b01, idx, arg});
    f = {2'b01, idx, arg, c, 1'b1};
    got_crc = '0;
    @(posedge clk); #(PERIOD/4);
    fall_edge = fe; cmd_idx = idx; cmd_arg = arg; start = 1'b1;
    @(posedge clk); #(PERIOD/4);
    start = 1'b0;
    for (int i = 0; i < 48; i++) begin
      @(posedge clk); #(PERIOD/4);
      if (i == 0) chk(cmd_oe == !fe, "R6 edge of first drive", 64'(cmd_oe), 64'(!fe));
      if (inject && i == 10) begin start = 1'b1; cmd_idx = ~idx; cmd_arg = ~arg; end
      if (inject && i == 12) start = 1'b0;
      #(PERIOD/2);
      req = (i < 40) ? "R2 message bit" : (i < 47) ? "R3 crc bit" : "R4 end bit";
      if (inject) req = {req, " R7"};
      chk(cmd_out === f[47 - i], req, 64'(cmd_out), 64'(f[47 - i]));
      chk(cmd_oe === 1'b1, "R4 oe during frame", 64'(cmd_oe), 64'd1);
      if (i >= 40 && i < 47) got_crc[46 - i] = cmd_out;
    end
    @(posedge clk); #(3*PERIOD/4);
    chk(done === 1'b1, "R5 done after end bit", 64'(done), 64'd1);
    chk(cmd_oe === 1'b0, "R5 released with done", 64'(cmd_oe), 64'd0);
    @(posedge clk); #(3*PERIOD/4);
    chk(done === 1'b0, "R5 done one cycle", 64'(done), 64'd0);
    chk(cmd_oe === 1'b0, "R1 R7 idle after frame", 64'(cmd_oe), 64'd0);
    @(posedge clk); #(3*PERIOD/4);
    chk(cmd_oe === 1'b0, "R1 R7 no second frame", 64'(cmd_oe), 64'd0);
  endtask

  initial begin
    logic [6:0] cc;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #(3*PERIOD/4);
    chk(cmd_oe === 1'b0, "R1 reset oe", 64'(cmd_oe), 64'd0);
    chk(done === 1'b0, "R1 reset done", 64'(done), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #(3*PERIOD/4);
    chk(cmd_oe === 1'b0, "R1 idle oe", 64'(cmd_oe), 64'd0);

    run_frame(6'd0, 32'd0, 1'b0, 1'b0, cc);
    chk(cc == 7'h4A, "R8 index 0 crc", 64'(cc), 64'h4A);
    run_frame(6'd17, 32'd0, 1'b1, 1'b0, cc);
    chk(cc == 7'h2A, "R8 index 17 crc", 64'(cc), 64'h2A);
    run_frame(6'h3F, 32'hFFFF_FFFF, 1'b0, 1'b1, cc);
    run_frame(6'h3F, 32'hFFFF_FFFF, 1'b1, 1'b1, cc);

    for (int k = 0; k < 24; k++) begin
      logic [5:0]  ri;
      logic [31:0] ra;
      bit rf, rj;
      ri = 6'($urandom);
      ra = $urandom;
      rf = 1'($urandom % 2);
      rj = (($urandom % 3) == 0);
      run_frame(ri, ra, rf, rj, cc);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule